// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves a conditional branch in one clock. Two register operands are compared under one of six conditions: equality, inequality, signed less-than, signed greater-or-equal, unsigned less-than and unsigned greater-or-equal. At the same time, a 13-bit branch offset is sign-extended and added to a base operand to form the destination address.

When the condition holds, the registered next address is that destination with its lowest bit cleared. When the condition fails, the next address is the fall-through address supplied by the caller. Two of the eight condition codes are reserved. Either reserved code raises an illegal flag and never produces a taken branch.

Results are captured only on a valid input cycle. The result-valid strobe trails the input strobe by exactly one clock.

Top module: `brcu_unit`

## Requirements
- R1: While `rst` is high and after it is released with no valid input, `res_valid`, `res_taken` and `res_illegal` are 0 and `res_next` is all zeros.
- R2: `res_valid` equals the value `req_valid` had at the previous rising clock edge.
- R3: On a taken branch, `res_next` equals `base_addr` plus the 13-bit `offset` sign-extended to XLEN bits, modulo 2^XLEN, with bit 0 then forced to 0.
- R4: Code 3'b000 is taken when `src_a` equals `src_b`. Code 3'b001 is taken when they differ.
- R5: Code 3'b100 is taken when `src_a` is less than `src_b` as two's-complement numbers, with the MSB as the sign bit. Code 3'b101 is taken in the complementary case.
- R6: Code 3'b110 is taken when `src_a` is less than `src_b` as unsigned magnitudes. Code 3'b111 is taken in the complementary case.
- R7: When the selected condition is false, `res_next` equals the `fall_addr` presented with the request, and `res_taken` is 0.
- R8: Codes 3'b010 and 3'b011 set `res_illegal` to 1, give `res_taken` 0, and give `res_next` equal to `fall_addr`. Every other code gives `res_illegal` 0.
- R9: On a cycle with `req_valid` low, `res_taken`, `res_illegal` and `res_next` keep the values from the last valid request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| src_a | input | XLEN | First compared operand |
| src_b | input | XLEN | Second compared operand |
| base_addr | input | XLEN | Base operand of the destination sum |
| offset | input | 13 | Signed branch offset |
| cond_code | input | 3 | Condition selector |
| fall_addr | input | XLEN | Address of the following instruction |
| res_valid | output | 1 | Result strobe, one clock after the request |
| res_taken | output | 1 | Branch taken |
| res_illegal | output | 1 | Reserved condition code seen |
| res_next | output | XLEN | Selected next address |

## Verification
Every result is registered one edge after its request. A fault in the compare, selection or adder logic therefore shows up at the next rising edge, as a wrong `res_taken` or `res_next` on that very request. Operand pairs that differ only in the MSB separate the signed comparisons from the unsigned ones, so a swapped signedness flips `res_taken` on that request. A faulty capture enable shows up as changed outputs on the first idle cycle after a request.

// File: rtl/brcu_pkg.sv
package brcu_pkg;

  localparam int OFFSET_W = 13;
  localparam int CODE_W   = 3;

  typedef enum logic [CODE_W-1:0] {
    COND_EQ   = 3'b000,
    COND_NE   = 3'b001,
    COND_RSV2 = 3'b010,
    COND_RSV3 = 3'b011,
    COND_SLT  = 3'b100,
    COND_SGE  = 3'b101,
    COND_ULT  = 3'b110,
    COND_UGE  = 3'b111
  } cond_e;

  function automatic logic code_reserved(input logic [CODE_W-1:0] code);
    return (code == COND_RSV2) || (code == COND_RSV3);
  endfunction

endpackage

// File: rtl/brcu_compare.sv
module brcu_compare #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            is_eq,
  output logic            is_lt_s,
  output logic            is_lt_u
);

  function automatic logic less_unsigned(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    logic [XLEN:0] diff;
    diff = {1'b0, x} - {1'b0, y};
    return diff[XLEN];
  endfunction

  function automatic logic less_signed(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    if (x[XLEN-1] != y[XLEN-1]) return x[XLEN-1];
    return less_unsigned(x, y);
  endfunction

  always_comb begin
    is_eq   = (a == b);
    is_lt_u = less_unsigned(a, b);
    is_lt_s = less_signed(a, b);
  end

endmodule

// File: rtl/brcu_cond_sel.sv
module brcu_cond_sel
  import brcu_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              is_eq,
  input  logic              is_lt_s,
  input  logic              is_lt_u,
  output logic              hit,
  output logic              reserved
);

  always_comb begin
    reserved = code_reserved(code);
    case (cond_e'(code))
      COND_EQ:  hit = is_eq;
      COND_NE:  hit = !is_eq;
      COND_SLT: hit = is_lt_s;
      COND_SGE: hit = !is_lt_s;
      COND_ULT: hit = is_lt_u;
      COND_UGE: hit = !is_lt_u;
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/brcu_target.sv
module brcu_target
  import brcu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]     base,
  input  logic [OFFSET_W-1:0] offset,
  output logic [XLEN-1:0]     target
);

  localparam int EXT_W = XLEN - OFFSET_W;

  function automatic logic [XLEN-1:0] widen(input logic [OFFSET_W-1:0] v);
    return {{EXT_W{v[OFFSET_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] even_sum(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    logic [XLEN-1:0] s;
    s = x + y;
    return {s[XLEN-1:1], 1'b0};
  endfunction

  assign target = even_sum(base, widen(offset));

endmodule

// File: rtl/brcu_unit.sv
module brcu_unit
  import brcu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [XLEN-1:0]     src_a,
  input  logic [XLEN-1:0]     src_b,
  input  logic [XLEN-1:0]     base_addr,
  input  logic [OFFSET_W-1:0] offset,
  input  logic [CODE_W-1:0]   cond_code,
  input  logic [XLEN-1:0]     fall_addr,
  output logic                res_valid,
  output logic                res_taken,
  output logic                res_illegal,
  output logic [XLEN-1:0]     res_next
);

  logic            cmp_eq;
  logic            cmp_lt_s;
  logic            cmp_lt_u;
  logic            cond_hit;
  logic            cond_rsv;
  logic [XLEN-1:0] dest_addr;
  logic            take_now;
  logic [XLEN-1:0] next_now;

  brcu_compare #(.XLEN(XLEN)) u_cmp (
    .a       (src_a),
    .b       (src_b),
    .is_eq   (cmp_eq),
    .is_lt_s (cmp_lt_s),
    .is_lt_u (cmp_lt_u)
  );

  brcu_cond_sel u_sel (
    .code     (cond_code),
    .is_eq    (cmp_eq),
    .is_lt_s  (cmp_lt_s),
    .is_lt_u  (cmp_lt_u),
    .hit      (cond_hit),
    .reserved (cond_rsv)
  );

  brcu_target #(.XLEN(XLEN)) u_tgt (
    .base   (base_addr),
    .offset (offset),
    .target (dest_addr)
  );

  assign take_now = cond_hit && !cond_rsv;
  assign next_now = take_now ? dest_addr : fall_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_taken   <= 1'b0;
      res_illegal <= 1'b0;
      res_next    <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_taken   <= take_now;
        res_illegal <= cond_rsv;
        res_next    <= next_now;
      end
    end
  end

  AST_VALID_TRAILS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid); // R2
  AST_IDLE_TRAILS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid); // R2
  AST_DEST_EVEN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && take_now) |=> (res_next[0] == 1'b0)); // R3
  AST_EQ_NOT_LESS: assert property (@(posedge clk) disable iff (rst)
    cmp_eq |-> (!cmp_lt_s && !cmp_lt_u)); // R5
  AST_MISS_FALLS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cond_hit) |=> (res_next == $past(fall_addr) && !res_taken)); // R7
  AST_RSV_NEVER_TAKEN: assert property (@(posedge clk) disable iff (rst)
    res_illegal |-> !res_taken); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(res_next) && $stable(res_taken) && $stable(res_illegal))); // R9

endmodule

// File: tb/test_brcu_unit.sv
`timescale 1ns/1ps
module test_brcu_unit;

  localparam int XLEN = 32;
  localparam real HALF = 2.5;

  logic            clk = 1'b0;
  logic            rst;
  logic            req_valid;
  logic [XLEN-1:0] src_a, src_b, base_addr, fall_addr;
  logic [12:0]     offset;
  logic [2:0]      cond_code;
  logic            res_valid, res_taken, res_illegal;
  logic [XLEN-1:0] res_next;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic            m_taken = 0;
  logic            m_ill = 0;
  logic [XLEN-1:0] m_next = '0;

  always #HALF clk = ~clk;

  brcu_unit #(.XLEN(XLEN)) i_brcu_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .src_a(src_a), .src_b(src_b),
    .base_addr(base_addr), .offset(offset), .cond_code(cond_code),
    .fall_addr(fall_addr), .res_valid(res_valid), .res_taken(res_taken),
    .res_illegal(res_illegal), .res_next(res_next)
  );

  function automatic logic model_take(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return $signed(a) < $signed(b);
      3'd5: return $signed(a) >= $signed(b);
      3'd6: return a < b;
      3'd7: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] model_dest(input logic [31:0] base, input logic [12:0] off);
    logic signed [31:0] ext;
    ext = 32'($signed(off));
    return (base + ext) & 32'hFFFF_FFFE;
  endfunction

  function automatic string tag_of(input logic [2:0] c, input logic took);
    if (c == 3'd2 || c == 3'd3) return "R8";
    if (!took) return "R7";
    if (c <= 3'd1) return "R4";
    if (c <= 3'd5) return "R5";
    return "R6";
  endfunction

  task automatic check1(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] base, input logic [12:0] off,
                      input logic [2:0] c, input logic [31:0] fall);
    string t;
    logic tk;
    @(negedge clk);
    req_valid = v; src_a = a; src_b = b; base_addr = base;
    offset = off; cond_code = c; fall_addr = fall;
    tk = model_take(c, a, b);
    if (v) begin
      m_taken = tk;
      m_ill   = (c == 3'd2 || c == 3'd3);
      m_next  = tk ? model_dest(base, off) : fall;
      t = tag_of(c, tk);
    end else begin
      t = "R9";
    end
    @(posedge clk);
    #1;
    check1("R2", 32'(res_valid), 32'(v));
    check1(t, 32'(res_taken), 32'(m_taken));
    check1(v ? "R8" : "R9", 32'(res_illegal), 32'(m_ill));
    check1((v && m_taken) ? "R3" : t, res_next, m_next);
  endtask

  initial begin
    #(2.0 * HALF * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'd4242);
    rst = 1'b1; req_valid = 0; src_a = 0; src_b = 0; base_addr = 0;
    offset = 0; cond_code = 0; fall_addr = 0;
    repeat (3) @(posedge clk);
    #1;
    check1("R1", 32'(res_valid), 0);
    check1("R1", 32'(res_taken), 0);
    check1("R1", 32'(res_illegal), 0);
    check1("R1", res_next, 0);
    @(negedge clk); rst = 1'b0;
    step(0, 0, 0, 0, 0, 0, 32'h44);
    // R4 equality pair
    step(1, 32'h1234, 32'h1234, 32'h1000, 13'h010, 3'd0, 32'h2004);
    step(1, 32'h1234, 32'h1234, 32'h1000, 13'h010, 3'd1, 32'h2004);
    // R5 / R6 sign-bit separation
    step(1, 32'h8000_0000, 32'h1, 32'h4000, 13'h020, 3'd4, 32'h4004);
    step(1, 32'h8000_0000, 32'h1, 32'h4000, 13'h020, 3'd6, 32'h4004);
    step(1, 32'h8000_0000, 32'h1, 32'h4000, 13'h020, 3'd7, 32'h4004);
    step(1, 32'h8000_0000, 32'h1, 32'h4000, 13'h020, 3'd5, 32'h4004);
    // R3 most negative offset and odd sum, wrap
    step(1, 5, 5, 32'h0000_0800, 13'h1000, 3'd0, 32'h4);
    step(1, 5, 5, 32'h0000_0101, 13'h0002, 3'd0, 32'h4);
    step(1, 5, 5, 32'hFFFF_FFFF, 13'h0FFF, 3'd7, 32'h4);
    // R8 reserved codes with true-looking operands
    step(1, 7, 7, 32'h100, 13'h8, 3'd2, 32'h900);
    step(1, 1, 7, 32'h100, 13'h8, 3'd3, 32'h904);
    // R9 idle cycles with changed inputs
    step(0, 1, 1, 32'hABC0, 13'h4, 3'd0, 32'h1);
    step(0, 2, 1, 32'h0, 13'h0, 3'd1, 32'h3);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = ($urandom % 4 == 0) ? a : $urandom;
      if ($urandom % 5 == 0) b = a ^ 32'h8000_0000;
      step(($urandom % 4) != 0, a, b, $urandom, 13'($urandom), 3'($urandom), $urandom);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule